// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block keeps the pointer state for a set of independent circular buffers and hands out one memory address per clock cycle. Each buffer holds four variables: a current index, a signed step, a window length and a window base. A fifth per-buffer field sets the bit count used when the address is formed in bit-reversed order. When a request names a buffer, the block returns that buffer's address on the next cycle. In the same cycle it moves the index by the step and folds it back into the window `[base, base+length)`. The datapath never stalls for this.

Software-style configuration writes load any field of any buffer. The bit-reversed form swaps the low bits of the offset from base, so that a buffer filled in natural order can be read out in the order an FFT stage needs. A length of zero turns the buffer into a plain linear pointer that wraps only at the top of the address space. The step magnitude is assumed to be smaller than the length, and the buffer count a power of two.

Top module: `cbag_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every field of every buffer is zero and addr_vld is low, so a first access to any buffer returns address 0.
- R2: One cycle after acc_req is high, addr_vld is high and, when acc_rev is low, addr_out equals the index of buffer acc_buf as it stood before that access. One cycle after acc_req is low, addr_vld is low.
- R3: After an access with nonzero length L, if index+step is at or above base+L, the new index is index+step−L. Otherwise, if it lies inside the window, the new index is index+step.
- R4: After an access with nonzero length L, if index+step is below base, the new index is index+step+L.
- R5: With length 0, the new index is index+step modulo 2^AW, and the window is not applied.
- R6: With acc_rev high, addr_out is base plus the offset (index−base mod 2^AW) with its low k bits put in reverse order and its higher bits unchanged. Here k is the buffer's reverse-width field, and values above AW count as AW, so k=0 gives the plain index. The index update is the same as in R3 to R5.
- R7: A configuration write (cfg_we high) sets field cfg_fld of buffer cfg_buf to cfg_data at the clock edge. The field codes are 0 index, 1 step (two's complement), 2 length, 3 base and 4 reverse width (low bits of cfg_data). An access in the following cycle uses the new value.
- R8: If, in one cycle, an access and a write of field code 0 target the same buffer, addr_out shows the old index and the stored index becomes the written value, not the post-modified one.
- R9: An access or write to one buffer leaves the fields of all other buffers unchanged.
- R10: Writes with field codes 5, 6 or 7 change no field of any buffer.
- R11: Accesses may be issued on every consecutive cycle. Each one yields its own address one cycle later, and each sees the index left by the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_buf | input | $clog2(NBUF) | Buffer selected for the write |
| cfg_fld | input | 3 | Field code: 0 index, 1 step, 2 length, 3 base, 4 reverse width |
| cfg_data | input | AW | Value written |
| acc_req | input | 1 | Address request this cycle |
| acc_buf | input | $clog2(NBUF) | Buffer selected for the request |
| acc_rev | input | 1 | Form the address in bit-reversed order |
| addr_out | output | AW | Generated address, valid when addr_vld is high |
| addr_vld | output | 1 | Address produced for the request of the previous cycle |

## Verification
A positive step running off the top of a window, and a negative step running off the bottom, tell the two fold directions apart from a plain add. A large step with zero length shows that the modulo-2^AW pointer ignores the window. A natural-order sweep through an eight-entry buffer with a three-bit reverse width must produce the permuted sequence. Zero and oversized reverse widths separate the identity and clamping cases. Back-to-back requests across different buffers, and writes colliding with accesses to the same buffer, show that each buffer keeps its own state and that the write wins the collision.

// File: rtl/cbag_pkg.sv
// Shared definitions for the circular buffer address generator.
// Assumes field codes are carried on a 3-bit configuration bus.
package cbag_pkg;

    // Field codes selected by cfg_fld; codes 5..7 are ignored.
    typedef enum logic [2:0] {
        FLD_INDEX = 3'd0,
        FLD_STEP  = 3'd1,
        FLD_SPAN  = 3'd2,
        FLD_BASE  = 3'd3,
        FLD_REVW  = 3'd4
    } cfg_field_e;

endpackage

// File: rtl/cbag_regfile.sv
// Per-buffer variable storage: index, step, length, base and reverse width
// for NBUF buffers. One configuration write port, one index update port
// driven by the access path, and one combinational read port.
// Assumes NBUF is a power of two. A configuration write to the index field
// overrides an index update to the same buffer in the same cycle.
module cbag_regfile
    import cbag_pkg::*;
#(
    parameter int NBUF = 8,
    parameter int AW   = 16,
    parameter int KW   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NBUF)-1:0] wr_buf,
    input  logic [2:0]              wr_fld,
    input  logic [AW-1:0]           wr_data,
    input  logic                    upd_en,
    input  logic [$clog2(NBUF)-1:0] upd_buf,
    input  logic [AW-1:0]           upd_idx,
    input  logic [$clog2(NBUF)-1:0] rd_buf,
    output logic [AW-1:0]           rd_idx,
    output logic [AW-1:0]           rd_step,
    output logic [AW-1:0]           rd_span,
    output logic [AW-1:0]           rd_base,
    output logic [KW-1:0]           rd_revw
);
    localparam int SW = $clog2(NBUF);

    logic [AW-1:0] idx_a  [NBUF];
    logic [AW-1:0] step_a [NBUF];
    logic [AW-1:0] span_a [NBUF];
    logic [AW-1:0] base_a [NBUF];
    logic [KW-1:0] revw_a [NBUF];

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        localparam logic [SW-1:0] ID = SW'(g);
        logic          hit_wr;
        logic          hit_upd;
        logic [AW-1:0] idx_r;
        logic [AW-1:0] step_r;
        logic [AW-1:0] span_r;
        logic [AW-1:0] base_r;
        logic [KW-1:0] revw_r;

        // Decode whether this buffer is the write or update target.
        always_comb begin
            hit_wr  = wr_en  && (wr_buf  == ID);
            hit_upd = upd_en && (upd_buf == ID);
        end

        // Hold this buffer's variables; the write beats the post-modify.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_r  <= '0;
                step_r <= '0;
                span_r <= '0;
                base_r <= '0;
                revw_r <= '0;
            end else begin
                if (hit_wr && wr_fld == FLD_INDEX) begin
                    idx_r <= wr_data;
                end else if (hit_upd) begin
                    idx_r <= upd_idx;
                end
                if (hit_wr && wr_fld == FLD_STEP) step_r <= wr_data;
                if (hit_wr && wr_fld == FLD_SPAN) span_r <= wr_data;
                if (hit_wr && wr_fld == FLD_BASE) base_r <= wr_data;
                if (hit_wr && wr_fld == FLD_REVW) revw_r <= wr_data[KW-1:0];
            end
        end

        assign idx_a[g]  = idx_r;
        assign step_a[g] = step_r;
        assign span_a[g] = span_r;
        assign base_a[g] = base_r;
        assign revw_a[g] = revw_r;
    end

    // Read port for the buffer currently being accessed.
    always_comb begin
        rd_idx  = idx_a[rd_buf];
        rd_step = step_a[rd_buf];
        rd_span = span_a[rd_buf];
        rd_base = base_a[rd_buf];
        rd_revw = revw_a[rd_buf];
    end

endmodule

// File: rtl/cbag_wrap.sv
// Post-modify arithmetic: adds a signed step to the index and folds the
// result back into [base, base+span). A span of zero leaves a plain
// modulo-2^AW add. Assumes |step| < span when span is nonzero.
module cbag_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] span,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lo;
    logic signed [EW-1:0] hi;
    logic signed [EW-1:0] ext_span;
    logic signed [EW-1:0] fixed;

    // Widen operands so the window compare sees no overflow.
    always_comb begin
        ext_span = $signed({2'b00, span});
        lo       = $signed({2'b00, base});
        hi       = lo + ext_span;
        sum      = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
    end

    // Choose the folded or linear result.
    always_comb begin
        if (span == '0) begin
            fixed = sum;
        end else if (sum >= hi) begin
            fixed = sum - ext_span;
        end else if (sum < lo) begin
            fixed = sum + ext_span;
        end else begin
            fixed = sum;
        end
        nxt = fixed[AW-1:0];
    end

endmodule

// File: rtl/cbag_revaddr.sv
// Address former: passes the index through, or in reverse mode forms
// base + offset with the low k offset bits mirrored. k comes from the
// reverse-width field and is clamped to AW.
module cbag_revaddr #(
    parameter int AW = 16,
    parameter int KW = 5
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [KW-1:0] revw,
    input  logic          rev_en,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] off;
    logic [AW-1:0] mir;
    int            k;

    // Clamp the reverse width to the address width.
    always_comb begin
        if (revw > KW'(AW)) k = AW;
        else                k = int'(revw);
    end

    // Mirror the low k bits of the offset from base.
    always_comb begin
        off = cur - base;
        for (int j = 0; j < AW; j++) begin
            mir[j] = off[j];
            for (int s = 0; s < AW; s++) begin
                if (j < k && s == k - 1 - j) mir[j] = off[s];
            end
        end
    end

    // Select the plain or reordered address.
    always_comb begin
        addr = rev_en ? (base + mir) : cur;
    end

endmodule

// File: rtl/cbag_top.sv
// Circular buffer address generator top. Reads the selected buffer,
// forms its address, post-modifies the index, and registers the address
// with a valid flag one cycle after the request.
// Assumes NBUF is a power of two and AW >= 2.
module cbag_top #(
    parameter int NBUF = 8,
    parameter int AW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [$clog2(NBUF)-1:0] cfg_buf,
    input  logic [2:0]              cfg_fld,
    input  logic [AW-1:0]           cfg_data,
    input  logic                    acc_req,
    input  logic [$clog2(NBUF)-1:0] acc_buf,
    input  logic                    acc_rev,
    output logic [AW-1:0]           addr_out,
    output logic                    addr_vld
);
    localparam int KW = $clog2(AW + 1);

    logic [AW-1:0] sel_idx;
    logic [AW-1:0] sel_step;
    logic [AW-1:0] sel_span;
    logic [AW-1:0] sel_base;
    logic [KW-1:0] sel_revw;
    logic [AW-1:0] next_idx;
    logic [AW-1:0] formed;
    logic [AW-1:0] addr_q;
    logic          vld_q;

    cbag_regfile #(.NBUF(NBUF), .AW(AW), .KW(KW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_buf  (cfg_buf),
        .wr_fld  (cfg_fld),
        .wr_data (cfg_data),
        .upd_en  (acc_req),
        .upd_buf (acc_buf),
        .upd_idx (next_idx),
        .rd_buf  (acc_buf),
        .rd_idx  (sel_idx),
        .rd_step (sel_step),
        .rd_span (sel_span),
        .rd_base (sel_base),
        .rd_revw (sel_revw)
    );

    cbag_wrap #(.AW(AW)) u_wrap (
        .cur  (sel_idx),
        .step (sel_step),
        .span (sel_span),
        .base (sel_base),
        .nxt  (next_idx)
    );

    cbag_revaddr #(.AW(AW), .KW(KW)) u_rev (
        .cur    (sel_idx),
        .base   (sel_base),
        .revw   (sel_revw),
        .rev_en (acc_rev),
        .addr   (formed)
    );

    // Register the formed address and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= acc_req;
            if (acc_req) addr_q <= formed;
        end
    end

    assign addr_out = addr_q;
    assign addr_vld = vld_q;

endmodule

// File: rtl/cbag_chk.sv
// Protocol checks for cbag_top, bound onto every instance.
module cbag_chk
    import cbag_pkg::*;
#(
    parameter int NBUF = 8,
    parameter int AW   = 16,
    parameter int KW   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [$clog2(NBUF)-1:0] cfg_buf,
    input logic [2:0]              cfg_fld,
    input logic [AW-1:0]           cfg_data,
    input logic                    acc_req,
    input logic [$clog2(NBUF)-1:0] acc_buf,
    input logic                    acc_rev,
    input logic [AW-1:0]           addr_out,
    input logic                    addr_vld,
    input logic [AW-1:0]           sel_idx,
    input logic [KW-1:0]           sel_revw
);
    // R2
    vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> addr_vld);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !addr_vld);

    // R2
    plain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_rev) |=> (addr_out == $past(sel_idx)));

    // R6
    rev_zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_rev && sel_revw == '0) |=> (addr_out == $past(sel_idx)));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && cfg_we && cfg_buf == acc_buf && cfg_fld == FLD_INDEX)
        ##1 (acc_buf == $past(acc_buf)) |-> (sel_idx == $past(cfg_data)));

endmodule

bind cbag_top cbag_chk #(.NBUF(NBUF), .AW(AW), .KW(KW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_buf  (cfg_buf),
    .cfg_fld  (cfg_fld),
    .cfg_data (cfg_data),
    .acc_req  (acc_req),
    .acc_buf  (acc_buf),
    .acc_rev  (acc_rev),
    .addr_out (addr_out),
    .addr_vld (addr_vld),
    .sel_idx  (sel_idx),
    .sel_revw (sel_revw)
);

// File: tb/tb_cbag_top.sv
// Scoreboard bench: the driver predicts each address from a spec model
// and queues it; the monitor pops and compares one cycle later.
module tb_cbag_top;
    localparam int NBUF = 8;
    localparam int AW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_buf = '0;
    logic [2:0]    cfg_fld = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          acc_req = 1'b0;
    logic [2:0]    acc_buf = '0;
    logic          acc_rev = 1'b0;
    logic [AW-1:0] addr_out;
    logic          addr_vld;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    int mI [NBUF];
    int mM [NBUF];
    int mL [NBUF];
    int mB [NBUF];
    int mK [NBUF];

    always #2 clk = ~clk;

    cbag_top #(.NBUF(NBUF), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_buf(cfg_buf),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .acc_req(acc_req),
        .acc_buf(acc_buf), .acc_rev(acc_rev), .addr_out(addr_out),
        .addr_vld(addr_vld)
    );

    function automatic int mwrap(int i, int m, int l, int b);
        int s;
        s = i + m;
        if (l != 0) begin
            if (s >= b + l) s = s - l;
            else if (s < b) s = s + l;
        end
        return s & 32'hFFFF;
    endfunction

    function automatic int mrev(int i, int b, int kf);
        int off, k, r;
        off = (i - b) & 32'hFFFF;
        k = (kf > AW) ? AW : kf;
        r = off;
        for (int j = 0; j < k; j++) begin
            r[j] = off[k - 1 - j];
        end
        return (b + r) & 32'hFFFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One driven cycle: optional write, optional access; model updated.
    task automatic cyc(bit we, int wb, int wf, int wd,
                       bit rq, int rb, bit rv, string tag);
        item_t it;
        @(negedge clk);
        cfg_we = we; cfg_buf = 3'(wb); cfg_fld = 3'(wf); cfg_data = AW'(wd);
        acc_req = rq; acc_buf = 3'(rb); acc_rev = rv;
        if (rq) begin
            it.exp = rv ? AW'(mrev(mI[rb], mB[rb], mK[rb])) : AW'(mI[rb]);
            it.tag = tag;
            sb.push_back(it);
            mI[rb] = mwrap(mI[rb], mM[rb], mL[rb], mB[rb]);
        end
        if (we) begin
            case (wf)
                0: mI[wb] = wd & 32'hFFFF;
                1: mM[wb] = int'($signed(16'(wd)));
                2: mL[wb] = wd & 32'hFFFF;
                3: mB[wb] = wd & 32'hFFFF;
                4: mK[wb] = wd & 32'h1F;
                default: ;
            endcase
        end
    endtask

    task automatic wr(int b, int f, int d);
        cyc(1, b, f, d, 0, 0, 0, "R7");
    endtask

    task automatic acc(int b, bit rv, string tag);
        cyc(0, 0, 0, 0, 1, b, rv, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compare each produced address with the queue head.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (addr_vld) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 actual=vld expected=no address");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, int'(addr_out), int'(it.exp));
                end
            end else if (sb.size() != 0) begin
                checks++; errors++;
                $display("FAIL R2 actual=no vld expected=%h", sb[0].exp);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NBUF; b++) begin
            mI[b] = 0; mM[b] = 0; mL[b] = 0; mB[b] = 0; mK[b] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 vld in reset", int'(addr_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after reset", int'(addr_vld), 0);
        // R1: every buffer starts at zero
        for (int b = 0; b < NBUF; b++) acc(b, 0, "R1");
        idle(1);

        // R3 / R11: positive step wraps past the top, back to back
        wr(1, 3, 100); wr(1, 2, 10); wr(1, 1, 3); wr(1, 0, 100);
        for (int i = 0; i < 6; i++) acc(1, 0, "R3 R11");

        // R4: negative step wraps below base
        wr(2, 3, 200); wr(2, 2, 8); wr(2, 1, 16'hFFFD); wr(2, 0, 201);
        for (int i = 0; i < 6; i++) acc(2, 0, "R4");

        // R5: zero length, modulo 2^AW pointer
        wr(3, 1, 16'h7000); wr(3, 0, 16'hA000);
        for (int i = 0; i < 4; i++) acc(3, 0, "R5");

        // R6: bit-reversed sweep of an eight-entry buffer
        wr(4, 3, 16'h40); wr(4, 2, 8); wr(4, 1, 1); wr(4, 0, 16'h40); wr(4, 4, 3);
        for (int i = 0; i < 10; i++) acc(4, 1, "R6");
        wr(4, 4, 0);
        acc(4, 1, "R6 k0");
        wr(5, 1, 1); wr(5, 0, 1); wr(5, 4, 31);
        acc(5, 1, "R6 clamp");
        idle(1);

        // R7: write then immediate access
        wr(1, 0, 105);
        acc(1, 0, "R7");
        // R8: write and access to the same buffer in one cycle
        cyc(1, 1, 0, 107, 1, 1, 0, "R8 old");
        acc(1, 0, "R8 new");
        // R9: other buffers kept their state
        acc(0, 0, "R9");
        acc(2, 0, "R9");
        acc(3, 0, "R9");
        // R10: reserved field codes ignored
        cyc(1, 1, 5, 16'h1234, 0, 0, 0, "");
        cyc(1, 1, 6, 16'h0, 0, 0, 0, "");
        cyc(1, 1, 7, 16'hFFFF, 0, 0, 0, "");
        for (int i = 0; i < 4; i++) acc(1, 0, "R10");
        idle(3);
        // R2: idle leaves valid low
        check("R2 idle vld", int'(addr_vld), 0);
        check("R2 queue drained", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule